// File: doc/BRIEF.md
# Time-Slot Hardware Task Scheduler

This block is the thread issue unit of a single-pipeline processor core. It keeps a program counter for each of four tasks and a 32-bit slot word made of sixteen 2-bit task numbers. On every clock it reads the slot under its pointer. It presents that slot's task number and the task's program counter as the fetch address, then moves the pointer on. Tasks therefore share the one pipeline instruction by instruction, and the interleave follows a fixed pattern.

The length of the rotation is not fixed at sixteen. The scheduler ignores the all-zero pairs at the top of the slot word, so a short word such as `0xE4` gives a 4-slot loop. Zero pairs that sit below the highest nonzero pair stay in the loop as slots for task 0. Two further inputs act on the program counters. A masked load writes one address into any subset of the task PCs. A per-cycle wait flag from the pipeline stops the issuing task's PC from advancing, so the same instruction is issued again on that task's next slot. To give the whole core to one task n, write n into every field of the slot word.

Top module: `task_slot_sched`

## Requirements
- R1: While rst_ni is low, and after it is released until the first clock edge, the outputs read task 0, PC 0, slot index 0 and rotation length 1.
- R2: Each clock issues exactly one slot. issue_task_o equals the 2-bit field at bits [2*i+1:2*i] of the slot word, where i is slot_idx_o. issue_pc_o equals the current PC of that task.
- R3: seq_len_o equals 16 minus the number of all-zero 2-bit pairs counted down from the top of the slot word.
- R4: A zero pair below the highest nonzero pair is a real slot for task 0. For the word `0xC84` the rotation is 6 slots long and issues tasks 0,1,0,2,0,3.
- R5: A slot word of all zeros gives a 1-slot rotation that always issues task 0.
- R6: The slot index starts at 0 (the least significant pair) and counts up by one each clock. After slot seq_len_o-1 it wraps to 0.
- R7: A word written with slot_we_i takes effect on the next clock, and the slot index restarts at 0 on that clock.
- R8: With pc_ld_i high, every task whose bit is set in pc_ld_mask_i (bit k selects task k) takes pc_ld_addr_i on the next clock. This load takes priority over the increment. Tasks whose mask bit is clear are not loaded.
- R9: When there is no load and no wait, the issuing task's PC rises by one after issue, wrapping modulo 2^PC_W. The PCs of all other tasks hold.
- R10: With stall_i high, the issuing task's PC holds, and the slot index still moves to the next slot.
- R11: A word that repeats the same nonzero task n in all sixteen fields gives a 16-slot rotation that issues only task n.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| slot_we_i | input | 1 | Write the slot word |
| slot_wdata_i | input | 32 | New slot word |
| pc_ld_i | input | 1 | Masked PC load strobe |
| pc_ld_mask_i | input | 4 | Task select for the load |
| pc_ld_addr_i | input | PC_W | Address loaded into the selected PCs |
| stall_i | input | 1 | The issued instruction is waiting and must be reissued |
| issue_task_o | output | 2 | Task number of the current slot |
| issue_pc_o | output | PC_W | Fetch address of the issuing task |
| slot_idx_o | output | 4 | Current slot pointer |
| seq_len_o | output | 5 | Active rotation length, 1 to 16 |

## Verification
A wrong slot pointer or a wrong length decode shows up on the next clock. The task sequence on issue_task_o leaves the expected pattern, and slot_idx_o either passes seq_len_o or wraps too early. A corrupted PC stays hidden until its task next owns a slot. Every task therefore has to be issued after each load, stall and increment, so that issue_pc_o is compared within one rotation. These comparisons are made under random slot words of varied length and under directed words.

// File: rtl/sched_pkg.sv
package sched_pkg;
  localparam int TASK_ID_W = 2;
  localparam int NUM_TASKS = 1 << TASK_ID_W;
  typedef logic [TASK_ID_W-1:0] task_id_t;
endpackage

// File: rtl/slot_len_calc.sv
module slot_len_calc
  import sched_pkg::*;
#(
  parameter int NUM_SLOTS = 16,
  localparam int SLOT_W = NUM_SLOTS * TASK_ID_W,
  localparam int LEN_W = $clog2(NUM_SLOTS) + 1
) (
  input  logic [SLOT_W-1:0] word_i,
  output logic [LEN_W-1:0]  len_o
);
  // highest nonzero pair sets the length; all-zero word gives 1
  always_comb begin
    len_o = LEN_W'(1);
    for (int i = 0; i < NUM_SLOTS; i++) begin
      if (word_i[i*TASK_ID_W +: TASK_ID_W] != '0) len_o = LEN_W'(i + 1);
    end
  end
endmodule

// File: rtl/slot_ptr_ctrl.sv
module slot_ptr_ctrl #(
  parameter int NUM_SLOTS = 16,
  localparam int IDX_W = $clog2(NUM_SLOTS),
  localparam int LEN_W = IDX_W + 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             restart_i,
  input  logic [LEN_W-1:0] len_i,
  output logic [IDX_W-1:0] idx_o
);
  logic [LEN_W-1:0] idx_inc;

  assign idx_inc = LEN_W'(idx_o) + LEN_W'(1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                idx_o <= '0;
    else if (restart_i)         idx_o <= '0;
    else if (idx_inc >= len_i)  idx_o <= '0;
    else                        idx_o <= idx_inc[IDX_W-1:0];
  end
endmodule

// File: rtl/task_pc_bank.sv
module task_pc_bank
  import sched_pkg::*;
#(
  parameter int PC_W = 16
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  task_id_t                       issue_task_i,
  input  logic                           stall_i,
  input  logic                           ld_i,
  input  logic [NUM_TASKS-1:0]           ld_mask_i,
  input  logic [PC_W-1:0]                ld_addr_i,
  output logic [NUM_TASKS-1:0][PC_W-1:0] pc_o
);
  for (genvar t = 0; t < NUM_TASKS; t++) begin : g_pc
    logic issuing;
    assign issuing = (issue_task_i == task_id_t'(t));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                   pc_o[t] <= '0;
      else if (ld_i && ld_mask_i[t]) pc_o[t] <= ld_addr_i;
      else if (issuing && !stall_i)  pc_o[t] <= pc_o[t] + PC_W'(1);
    end
  end
endmodule

// File: rtl/task_slot_sched.sv
module task_slot_sched
  import sched_pkg::*;
#(
  parameter int NUM_SLOTS = 16,
  parameter int PC_W = 16,
  localparam int SLOT_W = NUM_SLOTS * TASK_ID_W,
  localparam int IDX_W = $clog2(NUM_SLOTS),
  localparam int LEN_W = IDX_W + 1
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 slot_we_i,
  input  logic [SLOT_W-1:0]    slot_wdata_i,
  input  logic                 pc_ld_i,
  input  logic [NUM_TASKS-1:0] pc_ld_mask_i,
  input  logic [PC_W-1:0]      pc_ld_addr_i,
  input  logic                 stall_i,
  output logic [TASK_ID_W-1:0] issue_task_o,
  output logic [PC_W-1:0]      issue_pc_o,
  output logic [IDX_W-1:0]     slot_idx_o,
  output logic [LEN_W-1:0]     seq_len_o
);
  logic [SLOT_W-1:0]              slot_word_q;
  logic [NUM_TASKS-1:0][PC_W-1:0] pc;
  task_id_t                       cur_task;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        slot_word_q <= '0;
    else if (slot_we_i) slot_word_q <= slot_wdata_i;
  end

  slot_len_calc #(.NUM_SLOTS(NUM_SLOTS)) u_len (
    .word_i (slot_word_q),
    .len_o  (seq_len_o)
  );

  slot_ptr_ctrl #(.NUM_SLOTS(NUM_SLOTS)) u_ptr (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .restart_i (slot_we_i),
    .len_i     (seq_len_o),
    .idx_o     (slot_idx_o)
  );

  assign cur_task = slot_word_q[slot_idx_o*TASK_ID_W +: TASK_ID_W];

  task_pc_bank #(.PC_W(PC_W)) u_pcs (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .issue_task_i (cur_task),
    .stall_i      (stall_i),
    .ld_i         (pc_ld_i),
    .ld_mask_i    (pc_ld_mask_i),
    .ld_addr_i    (pc_ld_addr_i),
    .pc_o         (pc)
  );

  assign issue_task_o = cur_task;
  assign issue_pc_o   = pc[cur_task];
endmodule

// File: rtl/task_slot_sched_chk.sv
module task_slot_sched_chk
  import sched_pkg::*;
#(
  parameter int PC_W = 16,
  parameter int IDX_W = 4,
  parameter int LEN_W = 5
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 slot_we_i,
  input logic                 pc_ld_i,
  input logic [NUM_TASKS-1:0] pc_ld_mask_i,
  input logic [PC_W-1:0]      pc_ld_addr_i,
  input logic                 stall_i,
  input logic [TASK_ID_W-1:0] issue_task_o,
  input logic [PC_W-1:0]      issue_pc_o,
  input logic [IDX_W-1:0]     slot_idx_o,
  input logic [LEN_W-1:0]     seq_len_o
);
  assert_len_range_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seq_len_o >= LEN_W'(1)) && (seq_len_o <= LEN_W'(1 << IDX_W)));

  assert_idx_in_len_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    LEN_W'(slot_idx_o) < seq_len_o);

  assert_idx_step_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!slot_we_i && (LEN_W'(slot_idx_o) + LEN_W'(1) < seq_len_o))
    |=> (slot_idx_o == $past(slot_idx_o) + IDX_W'(1)));

  assert_idx_wrap_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!slot_we_i && (LEN_W'(slot_idx_o) + LEN_W'(1) == seq_len_o))
    |=> (slot_idx_o == '0));

  assert_restart_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    slot_we_i |=> (slot_idx_o == '0));

  // single-slot rotation: the same task issues again next cycle
  assert_pc_inc_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seq_len_o == LEN_W'(1) && !slot_we_i && !pc_ld_i && !stall_i)
    |=> (issue_pc_o == $past(issue_pc_o) + PC_W'(1)));

  assert_pc_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seq_len_o == LEN_W'(1) && !slot_we_i && !pc_ld_i && stall_i)
    |=> $stable(issue_pc_o));

  assert_pc_load_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seq_len_o == LEN_W'(1) && !slot_we_i && pc_ld_i && pc_ld_mask_i[issue_task_o])
    |=> (issue_pc_o == $past(pc_ld_addr_i)));
endmodule

bind task_slot_sched task_slot_sched_chk #(
  .PC_W(PC_W), .IDX_W(IDX_W), .LEN_W(LEN_W)
) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .slot_we_i    (slot_we_i),
  .pc_ld_i      (pc_ld_i),
  .pc_ld_mask_i (pc_ld_mask_i),
  .pc_ld_addr_i (pc_ld_addr_i),
  .stall_i      (stall_i),
  .issue_task_o (issue_task_o),
  .issue_pc_o   (issue_pc_o),
  .slot_idx_o   (slot_idx_o),
  .seq_len_o    (seq_len_o)
);

// File: tb/sim_task_slot_sched.sv
`timescale 1ns/1ps
module sim_task_slot_sched;
  localparam int PC_W = 16;

  logic            clk = 0;
  logic            rst_ni = 0;
  logic            slot_we = 0;
  logic [31:0]     slot_wdata = '0;
  logic            pc_ld = 0;
  logic [3:0]      pc_ld_mask = '0;
  logic [PC_W-1:0] pc_ld_addr = '0;
  logic            stall = 0;
  logic [1:0]      issue_task;
  logic [PC_W-1:0] issue_pc;
  logic [3:0]      slot_idx;
  logic [4:0]      seq_len;

  always #2 clk = ~clk;

  task_slot_sched #(.NUM_SLOTS(16), .PC_W(PC_W)) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .slot_we_i(slot_we), .slot_wdata_i(slot_wdata),
    .pc_ld_i(pc_ld), .pc_ld_mask_i(pc_ld_mask), .pc_ld_addr_i(pc_ld_addr),
    .stall_i(stall), .issue_task_o(issue_task), .issue_pc_o(issue_pc),
    .slot_idx_o(slot_idx), .seq_len_o(seq_len)
  );

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  logic [31:0]     m_word;
  int              m_ptr;
  logic [PC_W-1:0] m_pc [4];

  function automatic int f_len(logic [31:0] w);
    int l = 1;
    for (int i = 0; i < 16; i++) if (w[2*i +: 2] != 2'b00) l = i + 1;
    return l;
  endfunction

  function automatic logic [1:0] f_task(logic [31:0] w, int i);
    return w[2*i +: 2];
  endfunction

  task automatic chk(string req, string what, longint got, longint exp);
    n_chk++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s %s: got %0h expected %0h", req, what, got, exp);
    end
  endtask

  task automatic cmp_model(string tag);
    logic [1:0] t = f_task(m_word, m_ptr);
    chk(tag, "task", issue_task, t);
    chk(tag, "pc", issue_pc, m_pc[t]);
    chk("R6", "slot index", slot_idx, m_ptr);
    chk("R3", "length", seq_len, f_len(m_word));
  endtask

  // at a negedge: compare, drive, advance model, move to next negedge
  task automatic step(string tag, bit we, logic [31:0] wd, bit ld,
                      logic [3:0] msk, logic [PC_W-1:0] adr, bit st);
    logic [1:0] t;
    cmp_model(tag);
    slot_we = we; slot_wdata = wd; pc_ld = ld; pc_ld_mask = msk;
    pc_ld_addr = adr; stall = st;
    t = f_task(m_word, m_ptr);
    for (int k = 0; k < 4; k++) begin
      if (ld && msk[k])              m_pc[k] = adr;
      else if (k == int'(t) && !st)  m_pc[k] = m_pc[k] + 1'b1;
    end
    if (we) begin
      m_word = wd; m_ptr = 0;
    end else begin
      m_ptr = (m_ptr + 1 >= f_len(m_word)) ? 0 : m_ptr + 1;
    end
    @(negedge clk);
    slot_we = 0; pc_ld = 0; stall = 0;
  endtask

  task automatic idle(string tag, int n);
    for (int i = 0; i < n; i++) step(tag, 0, '0, 0, '0, '0, 0);
  endtask

  initial begin
    int seed_dummy;
    seed_dummy = $urandom(32'h5eed_1234);
    m_word = '0; m_ptr = 0;
    for (int k = 0; k < 4; k++) m_pc[k] = '0;
    repeat (2) @(negedge clk);
    chk("R1", "task in reset", issue_task, 0);
    chk("R1", "pc in reset", issue_pc, 0);
    rst_ni = 1;
    chk("R1", "index after reset", slot_idx, 0);
    chk("R1", "length after reset", seq_len, 1);

    // R9 single task running freely, R10 stall
    idle("R9", 3);
    step("R10", 0, '0, 0, '0, '0, 1);
    step("R10", 0, '0, 0, '0, '0, 1);
    chk("R10", "pc held by stall", issue_pc, 16'd3);

    // R3/R6: 4-slot loop
    step("R7", 1, 32'h0000_00E4, 0, '0, '0, 0);
    chk("R7", "index after write", slot_idx, 0);
    chk("R3", "length of 0xE4", seq_len, 4);
    for (int i = 0; i < 5; i++) begin
      chk("R6", "task order 0xE4", issue_task, i % 4);
      step("R6", 0, '0, 0, '0, '0, 0);
    end

    // R4: interior zero pairs
    step("R4", 1, 32'h0000_0C84, 0, '0, '0, 0);
    chk("R4", "length of 0xC84", seq_len, 6);
    begin
      int exp_seq [6] = '{0, 1, 0, 2, 0, 3};
      for (int i = 0; i < 12; i++) begin
        chk("R4", "task order 0xC84", issue_task, exp_seq[i % 6]);
        step("R4", 0, '0, 0, '0, '0, i == 3);
      end
    end

    // R8: masked load while rotating
    step("R8", 0, '0, 1, 4'b1010, 16'h1234, 0);
    idle("R8", 6);
    step("R8", 0, '0, 1, 4'b0101, 16'hBEEF, 1);
    idle("R8", 8);

    // R5: all-zero word
    step("R5", 1, 32'h0, 0, '0, '0, 0);
    chk("R5", "length of zero word", seq_len, 1);
    for (int i = 0; i < 3; i++) begin
      chk("R5", "zero word task", issue_task, 0);
      step("R5", 0, '0, 0, '0, '0, 0);
    end

    // R11: switch to task 2 with current-task PC load
    step("R11", 1, 32'hAAAA_AAAA, 1, 4'b0001, 16'h0400, 0);
    chk("R11", "length all-task-2", seq_len, 16);
    for (int i = 0; i < 18; i++) begin
      chk("R11", "all slots task 2", issue_task, 2);
      step("R11", 0, '0, 0, '0, '0, 0);
    end
    step("R11", 1, 32'hFFFF_FFFF, 0, '0, '0, 0);
    chk("R11", "length all-task-3", seq_len, 16);
    chk("R11", "all slots task 3", issue_task, 3);

    // random phase
    for (int i = 0; i < 3000; i++) begin
      bit we = ($urandom % 16) == 0;
      logic [31:0] wd = $urandom >> (2 * ($urandom % 16));
      bit ld = ($urandom % 8) == 0;
      logic [3:0] msk = 4'($urandom);
      logic [PC_W-1:0] adr = PC_W'($urandom);
      bit st = ($urandom % 4) == 0;
      step("R2", we, wd, ld, msk, adr, st);
    end
    cmp_model("R2");

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule